// File: doc/BRIEF.md
# Host Read-Strobe Glitch Filter

This block sits between the active-low read strobe of a 16-bit host bus and a memory-emulation engine that answers each host read. The strobe arrives with no timing relation to the local clock. The block synchronises it, turns the start of each host read into exactly one single-cycle request, and captures the host word address on that same cycle.

Real bus strobes can ring. A short high spike in the middle of a long read must not look like the end of one read and the start of another. If it did, the engine would serve the same address twice and still be busy when the next real read arrived. The filter is therefore asymmetric. A low level after an idle period raises a request promptly. The read ends only after the synchronised strobe has stayed high for a set number of consecutive clocks. Shorter high runs are absorbed into the current read and counted on a saturating debug counter.

While a read is active, the word returned by the engine is held on the data output with an enable flag. The flag drops, releasing the bus, once the read ends.

Top module: `rd_strobe_filter`

## Requirements
- R1: After reset, `readReq` and `busDataOe` are 0 and `glitchCount` is 0. No request is issued until a low strobe has been sampled.
- R2: With the default two synchroniser stages, a strobe that goes low before rising edge k, after the filter is idle, gives a `readReq` pulse that is high from edge k+2 and lasts exactly one clock. Each host read gives exactly one pulse.
- R3: `reqAddr` equals `hostWordAddr` (host byte address bits 23..1) as sampled when the request is raised. It holds that value until the next request.
- R4: During an active read, a high run of the synchronised strobe shorter than `DEASSERT_CLKS` (default 4) clocks raises no new request and keeps the read active, so `busDataOe` stays 1.
- R5: Each such short high run increments `glitchCount` by exactly one. The counter saturates at all ones (255 by default).
- R6: A high run of `DEASSERT_CLKS` clocks ends the read. With a strobe going high before edge j, `busDataOe` is still 1 after edge j+4 and is 0 after edge j+5. A low strobe after that raises a new request, even if the gap was exactly `DEASSERT_CLKS` clocks.
- R7: When `rdValid` is seen during an active read, `busData` shows `rdData` from the next clock on. `busDataOe` is 1 from then until the read ends.
- R8: `rdValid` while no read is active is ignored: `busDataOe` stays 0.
- R9: `busDataOe` is 0 in any cycle where `readReq` is 1. Data from a previous read is never presented for a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| oeN | input | 1 | Asynchronous active-low host read strobe |
| hostWordAddr | input | 23 | Host byte address bits 23..1 (word address) |
| rdValid | input | 1 | Engine has a word ready for the current read |
| rdData | input | 16 | Word returned by the engine |
| readReq | output | 1 | One-cycle read request to the engine |
| reqAddr | output | 23 | Word address captured with the request |
| busData | output | 16 | Word presented to the host |
| busDataOe | output | 1 | Drive enable for `busData` |
| glitchCount | output | 8 | Saturating count of suppressed high spikes |

## Verification
The bench drives high spikes of one, two and three clocks into long reads. A filter that treats any high sample as the end of a read would issue a second request for the same address, and the scoreboard would report it as a request it did not expect. It places two reads exactly `DEASSERT_CLKS` clocks apart. A filter that is too sluggish would merge them, and one expected address would never be popped. It times the request edge and the release edge cycle by cycle, fires `rdValid` while the filter is idle, and pushes the glitch counter past its top to show that it sticks at all ones instead of wrapping.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } rsfState_e;

  // Strobes from the control FSM to the datapath; each is one cycle wide.
  typedef struct packed {
    logic startRead;
    logic endRead;
    logic glitchSeen;
  } rsfStrobes_t;

endpackage

// File: rtl/rsf_sync.sv
module rsf_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/rsf_ctrl.sv
module rsf_ctrl
  import rsf_pkg::*;
#(
  parameter int DEASSERT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeHigh,
  output rsfStrobes_t strobes,
  output logic        readActive
);

  localparam int RUN_W = (DEASSERT_CLKS < 2) ? 1 : $clog2(DEASSERT_CLKS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(DEASSERT_CLKS - 1);

  rsfState_e        state, stateNext;
  logic [RUN_W-1:0] highRun, highRunNext;

  always_comb begin
    stateNext   = state;
    highRunNext = highRun;
    strobes     = '0;
    unique case (state)
      ST_IDLE: begin
        if (!strobeHigh) begin
          strobes.startRead = 1'b1;
          stateNext         = ST_ACTIVE;
          highRunNext       = '0;
        end
      end
      ST_ACTIVE: begin
        if (strobeHigh) begin
          if (highRun == RUN_LAST) begin
            strobes.endRead = 1'b1;
            stateNext       = ST_IDLE;
            highRunNext     = '0;
          end else begin
            highRunNext = highRun + 1'b1;
          end
        end else if (highRun != '0) begin
          // high run too short to qualify: absorb it into the current read
          strobes.glitchSeen = 1'b1;
          highRunNext        = '0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      highRun <= '0;
    end else begin
      state   <= stateNext;
      highRun <= highRunNext;
    end
  end

  assign readActive = (state == ST_ACTIVE);

endmodule

// File: rtl/rsf_datapath.sv
module rsf_datapath
  import rsf_pkg::*;
#(
  parameter int WADDR_W  = 23,
  parameter int DATA_W   = 16,
  parameter int GLITCH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  rsfStrobes_t         strobes,
  input  logic                readActive,
  input  logic [WADDR_W-1:0]  hostWordAddr,
  input  logic                rdValid,
  input  logic [DATA_W-1:0]   rdData,
  output logic                readReq,
  output logic [WADDR_W-1:0]  reqAddr,
  output logic [DATA_W-1:0]   busData,
  output logic                busDataOe,
  output logic [GLITCH_W-1:0] glitchCount
);

  localparam logic [GLITCH_W-1:0] GLITCH_MAX = '1;

  logic [DATA_W-1:0] dataReg;
  logic              dataLoaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readReq <= 1'b0;
      reqAddr <= '0;
    end else begin
      readReq <= strobes.startRead;
      if (strobes.startRead) reqAddr <= hostWordAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg    <= '0;
      dataLoaded <= 1'b0;
    end else if (strobes.startRead || strobes.endRead) begin
      dataLoaded <= 1'b0;
    end else if (rdValid && readActive) begin
      dataReg    <= rdData;
      dataLoaded <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glitchCount <= '0;
    end else if (strobes.glitchSeen && glitchCount != GLITCH_MAX) begin
      glitchCount <= glitchCount + 1'b1;
    end
  end

  assign busData   = dataReg;
  assign busDataOe = dataLoaded;

endmodule

// File: rtl/rd_strobe_filter.sv
module rd_strobe_filter
  import rsf_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int DEASSERT_CLKS = 4,
  parameter int GLITCH_W      = 8,
  localparam int WADDR_W      = ADDR_W - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                oeN,
  input  logic [WADDR_W-1:0]  hostWordAddr,
  input  logic                rdValid,
  input  logic [DATA_W-1:0]   rdData,
  output logic                readReq,
  output logic [WADDR_W-1:0]  reqAddr,
  output logic [DATA_W-1:0]   busData,
  output logic                busDataOe,
  output logic [GLITCH_W-1:0] glitchCount
);

  logic        oeHigh;
  logic        readActive;
  rsfStrobes_t strobes;

  rsf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(oeN), .syncOut(oeHigh)
  );

  rsf_ctrl #(.DEASSERT_CLKS(DEASSERT_CLKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .strobeHigh(oeHigh),
    .strobes(strobes), .readActive(readActive)
  );

  rsf_datapath #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .GLITCH_W(GLITCH_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .readActive(readActive),
    .hostWordAddr(hostWordAddr), .rdValid(rdValid), .rdData(rdData),
    .readReq(readReq), .reqAddr(reqAddr), .busData(busData),
    .busDataOe(busDataOe), .glitchCount(glitchCount)
  );

endmodule

// File: rtl/rd_strobe_filter_chk.sv
module rd_strobe_filter_chk #(
  parameter int WADDR_W  = 23,
  parameter int GLITCH_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                oeHigh,
  input logic                readReq,
  input logic [WADDR_W-1:0]  reqAddr,
  input logic                busDataOe,
  input logic                rdValid,
  input logic [GLITCH_W-1:0] glitchCount
);

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    readReq |=> !readReq);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |-> $stable(reqAddr));

  // R5
  glitch_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(glitchCount) |-> glitchCount == GLITCH_W'($past(glitchCount) + 1'b1));

  // R5
  glitch_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(glitchCount) == '1) |-> glitchCount == '1);

  // R6
  release_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDataOe) |-> $past(oeHigh));

  // R7
  oe_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDataOe) |-> $past(rdValid));

  // R9
  no_stale_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    readReq |-> !busDataOe);

endmodule

bind rd_strobe_filter rd_strobe_filter_chk #(.WADDR_W(WADDR_W), .GLITCH_W(GLITCH_W)) i_chk (
  .clk(clk), .rstN(rstN), .oeHigh(oeHigh), .readReq(readReq), .reqAddr(reqAddr),
  .busDataOe(busDataOe), .rdValid(rdValid), .glitchCount(glitchCount)
);

// File: tb/test_rd_strobe_filter.sv
`timescale 1ns/1ps
module test_rd_strobe_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oeN = 1'b1;
  logic [22:0] hostWordAddr = '0;
  logic        engValid = 1'b0;
  logic        strayValid = 1'b0;
  logic [15:0] rdData = '0;
  logic        readReq;
  logic [22:0] reqAddr;
  logic [15:0] busData;
  logic        busDataOe;
  logic [7:0]  glitchCount;

  int checks = 0;
  int fails = 0;
  int expGlitch = 0;
  logic [15:0] curExpData = '0;
  logic [22:0] expQ[$];

  always #2.5 clk = ~clk;

  rd_strobe_filter i_rd_strobe_filter (
    .clk(clk), .rstN(rstN), .oeN(oeN), .hostWordAddr(hostWordAddr),
    .rdValid(engValid | strayValid), .rdData(rdData),
    .readReq(readReq), .reqAddr(reqAddr), .busData(busData),
    .busDataOe(busDataOe), .glitchCount(glitchCount)
  );

  function automatic logic [15:0] wordOf(input logic [22:0] a);
    return a[15:0] ^ 16'h5AC3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: each request is popped against the expected queue.
  always @(negedge clk) begin
    if (rstN && readReq) begin
      if (expQ.size() == 0) begin
        check("R4 unexpected request", {9'd0, reqAddr}, 32'hFFFF_FFFF);
      end else begin
        logic [22:0] e;
        e = expQ.pop_front();
        check("R3 request address", {9'd0, reqAddr}, {9'd0, e});
      end
    end
    if (rstN && busDataOe) check("R7 data word", {16'd0, busData}, {16'd0, curExpData});
  end

  // Engine model: answers each request two clocks later.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && readReq) begin
        logic [22:0] a;
        a = reqAddr;
        repeat (2) @(negedge clk);
        rdData     = wordOf(a);
        curExpData = wordOf(a);
        engValid   = 1'b1;
        @(negedge clk);
        engValid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic startRead(input logic [22:0] a);
    expQ.push_back(a);
    hostWordAddr = a;
    oeN = 1'b0;
  endtask

  // Spikes of glitchLen clocks, each followed by lowCyc low clocks.
  task automatic spikes(input int count, input int glitchLen, input int lowCyc);
    for (int i = 0; i < count; i++) begin
      oeN = 1'b1;
      repeat (glitchLen) @(negedge clk);
      oeN = 1'b0;
      repeat (lowCyc) @(negedge clk);
      if (expGlitch < 255) expGlitch++;
    end
  endtask

  task automatic endRead();
    oeN = 1'b1;
    repeat (8) @(negedge clk);
    check("R6 released", {31'd0, busDataOe}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 readReq", {31'd0, readReq}, 32'd0);
    check("R1 busDataOe", {31'd0, busDataOe}, 32'd0);
    check("R1 glitchCount", {24'd0, glitchCount}, 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 no request while idle", {31'd0, readReq}, 32'd0);

    // R2 request timing
    startRead(23'h03C2A9);
    @(negedge clk); check("R2 no early request", {31'd0, readReq}, 32'd0);
    @(negedge clk); check("R2 no early request", {31'd0, readReq}, 32'd0);
    @(negedge clk); check("R2 request edge", {31'd0, readReq}, 32'd1);
    @(negedge clk); check("R2 one cycle wide", {31'd0, readReq}, 32'd0);
    repeat (6) @(negedge clk);
    check("R7 data enabled", {31'd0, busDataOe}, 32'd1);
    // R6 exact release timing
    oeN = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 still enabled", {31'd0, busDataOe}, 32'd1);
    @(negedge clk);
    check("R6 release edge", {31'd0, busDataOe}, 32'd0);
    repeat (4) @(negedge clk);

    // R4/R5 spikes of 1, 2 and 3 clocks inside long reads
    for (int len = 1; len <= 3; len++) begin
      startRead(23'h100000 + 23'(len * 16'h1111));
      repeat (10) @(negedge clk);
      spikes(2, len, 6);
      check("R4 read stays active", {31'd0, busDataOe}, 32'd1);
      check("R5 glitch count", {24'd0, glitchCount}, 32'(expGlitch));
      endRead();
    end

    // R6 back-to-back reads with a gap of exactly the qualifying length
    startRead(23'h079852 >> 1);
    repeat (10) @(negedge clk);
    oeN = 1'b1;
    repeat (4) @(negedge clk);
    startRead(23'h071FC4 >> 1);
    repeat (10) @(negedge clk);
    check("R6 second read served", {31'd0, busDataOe}, 32'd1);
    check("R6 both requests seen", 32'(expQ.size()), 32'd0);
    check("R5 gap not a glitch", {24'd0, glitchCount}, 32'(expGlitch));
    endRead();

    // R8 stray valid while idle
    @(negedge clk); strayValid = 1'b1; rdData = 16'hDEAD;
    @(negedge clk); strayValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 stray valid ignored", {31'd0, busDataOe}, 32'd0);

    // R5 saturation
    startRead(23'h2ABCDE);
    repeat (10) @(negedge clk);
    spikes(260, 1, 3);
    repeat (4) @(negedge clk);
    check("R5 saturated count", {24'd0, glitchCount}, 32'd255);
    check("R4 read active after spikes", {31'd0, busDataOe}, 32'd1);
    endRead();

    repeat (4) @(negedge clk);
    check("R2 all requests issued", 32'(expQ.size()), 32'd0);
    finishRun();
  end

endmodule